// File: doc/BRIEF.md
# DRAM Bank Conflict Detection Pipeline

This block sits at the front of a DRAM controller. It takes one request address per cycle and splits it into device, bank, row and column fields. It looks up the state of each bank's open page and decides which memory action the request needs. It then holds any request that would disturb a bank still serving a recent command to a different row. Requests aimed at idle banks, or at the row a bank already has open, go through without a stall. Banks can therefore work in parallel while conflicting requests wait for their bank.

The work is spread over three stages. The first stage registers the decoded fields. The second stage registers the chosen action. The third stage checks for a conflict and issues the request. When a request issues, the bank table records the row now open in that bank and starts a busy window of `BUSY_CYC` cycles for the bank. The issue stage may still hold a request to the same bank. That request's row is forwarded into the lookup, so the next request sees the newest bank state. Requests issue in the order they were accepted, and a held request stalls the requests behind it.

Top module: `dram_bank_pipe`

## Requirements
- R1: The address splits, from the least significant bit up, into column (`COL_W` bits), bank (`BANK_W`), row (`ROW_W`) and device (`DEV_W`). The issued request carries these four fields unchanged.
- R2: After reset no request is issued, `req_ready` is high and every bank of every device counts as closed.
- R3: A request to a closed bank issues with `iss_cmd` = 1, which means activate then access.
- R4: A request to a bank whose open row equals the request row issues with `iss_cmd` = 0, which means column access only.
- R5: A request to a bank with a different row open issues with `iss_cmd` = 2, which means precharge, activate, then access. The value 3 never appears on a valid issue.
- R6: The lookup uses the row of the request in the stage directly ahead when that request targets the same device and bank. A back-to-back request to the same row therefore gets 0, and one to a different row gets 2.
- R7: A request accepted on clock edge N, with nothing held ahead of it, has `iss_valid` high during the cycle after edge N+1.
- R8: An issue starts a busy window of `BUSY_CYC` cycles on that device and bank. A request with `iss_cmd` 1 or 2 to a busy bank is held and issues exactly `BUSY_CYC`+1 cycles after the issue that opened the window. Two consecutive issues never target the same device and bank with different rows.
- R9: A request with `iss_cmd` 0 is not held by a busy window on its bank.
- R10: A request to a different bank issues in the cycle right after the previous issue, even while that bank is busy.
- R11: Requests issue in acceptance order. While a request is held, `req_ready` goes low once the first stage is also occupied, and it is low only when a request is held.
- R12: Banks with the same bank number on different devices are tracked separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request address is valid |
| req_ready | output | 1 | Pipeline accepts a request on this edge |
| req_addr | input | DEV_W+ROW_W+BANK_W+COL_W | Request address |
| iss_valid | output | 1 | A request is issued this cycle |
| iss_cmd | output | 2 | Action: 0 access, 1 activate+access, 2 precharge+activate+access |
| iss_dev | output | DEV_W | Issued device field |
| iss_bank | output | BANK_W | Issued bank field |
| iss_row | output | ROW_W | Issued row field |
| iss_col | output | COL_W | Issued column field |

## Verification
The bench builds the block with one device bit, two bank bits, three row bits, two column bits and a busy window of 4 cycles. With an 8-bit address, every field position can be checked with distinct values. The short window lets the bench measure the exact release cycle of a held request and the in-order stall behind it. Having two devices exposes the case where the same bank number sits on different devices.

// File: rtl/dram_bank_pipe.sv
`timescale 1ns/1ps
module dram_bank_pipe #(
  parameter int DEV_W    = 1,
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 4,
  parameter int BUSY_CYC = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [DEV_W+ROW_W+BANK_W+COL_W-1:0]  req_addr,
  output logic                                 iss_valid,
  output logic [1:0]                           iss_cmd,
  output logic [DEV_W-1:0]                     iss_dev,
  output logic [BANK_W-1:0]                    iss_bank,
  output logic [ROW_W-1:0]                     iss_row,
  output logic [COL_W-1:0]                     iss_col
);
  localparam int ID_W  = DEV_W + BANK_W;
  localparam int NB    = 1 << ID_W;
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [1:0] CMD_HIT = 2'd0, CMD_EMPTY = 2'd1, CMD_MISS = 2'd2;

  logic              s1_v, s2_v;
  logic [DEV_W-1:0]  s1_dev, s2_dev;
  logic [BANK_W-1:0] s1_bank, s2_bank;
  logic [ROW_W-1:0]  s1_row, s2_row;
  logic [COL_W-1:0]  s1_col, s2_col;
  logic [1:0]        s2_cmd, look_cmd;

  logic [NB-1:0]     open_q;
  logic [ROW_W-1:0]  row_q  [NB];
  logic [CNT_W-1:0]  busy_q [NB];

  wire [ID_W-1:0] s1_id = {s1_dev, s1_bank};
  wire [ID_W-1:0] s2_id = {s2_dev, s2_bank};
  wire fwd      = s2_v && (s2_id == s1_id);
  wire conflict = s2_v && (busy_q[s2_id] != '0) && (s2_cmd != CMD_HIT);
  wire s2_adv   = !s2_v || iss_valid;

  assign iss_valid = s2_v && !conflict;
  assign req_ready = !s1_v || s2_adv;
  assign iss_cmd   = s2_cmd;
  assign iss_dev   = s2_dev;
  assign iss_bank  = s2_bank;
  assign iss_row   = s2_row;
  assign iss_col   = s2_col;

  always_comb begin
    if (fwd)                  look_cmd = (s2_row == s1_row) ? CMD_HIT : CMD_MISS;
    else if (!open_q[s1_id])  look_cmd = CMD_EMPTY;
    else                      look_cmd = (row_q[s1_id] == s1_row) ? CMD_HIT : CMD_MISS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      {s1_dev, s1_row, s1_bank, s1_col} <= '0;
    end else if (req_ready) begin
      s1_v <= req_valid;
      {s1_dev, s1_row, s1_bank, s1_col} <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0;
      s2_cmd <= CMD_HIT;
      {s2_dev, s2_row, s2_bank, s2_col} <= '0;
    end else if (s2_adv) begin
      s2_v <= s1_v;
      s2_cmd <= look_cmd;
      {s2_dev, s2_row, s2_bank, s2_col} <= {s1_dev, s1_row, s1_bank, s1_col};
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_bank
    wire hit_me = iss_valid && (s2_id == ID_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[i] <= 1'b0;
        row_q[i]  <= '0;
        busy_q[i] <= '0;
      end else if (hit_me) begin
        open_q[i] <= 1'b1;
        row_q[i]  <= s2_row;
        busy_q[i] <= CNT_W'(BUSY_CYC);
      end else if (busy_q[i] != '0) begin
        busy_q[i] <= busy_q[i] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_bank_pipe_chk.sv
`timescale 1ns/1ps
module dram_bank_pipe_chk #(
  parameter int DEV_W  = 1,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              iss_valid,
  input logic [1:0]        iss_cmd,
  input logic [DEV_W-1:0]  iss_dev,
  input logic [BANK_W-1:0] iss_bank,
  input logic [ROW_W-1:0]  iss_row,
  input logic              s2_v
);
  p_cmd_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> iss_cmd != 2'd3);

  p_same_row_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid) && {iss_dev, iss_bank, iss_row} == $past({iss_dev, iss_bank, iss_row}))
      |-> iss_cmd == 2'd0);

  p_no_b2b_conflict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid && $past(iss_valid) && {iss_dev, iss_bank} == $past({iss_dev, iss_bank})
      && iss_row != $past(iss_row)));

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && !iss_valid) |=> $stable({iss_cmd, iss_dev, iss_bank, iss_row}));

  p_ready_low_only_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (s2_v && !iss_valid));
endmodule

bind dram_bank_pipe dram_bank_pipe_chk #(.DEV_W(DEV_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .iss_valid(iss_valid),
  .iss_cmd(iss_cmd), .iss_dev(iss_dev), .iss_bank(iss_bank), .iss_row(iss_row),
  .s2_v(s2_v));

// File: tb/dram_bank_pipe_bench.sv
`timescale 1ns/1ps
module dram_bank_pipe_bench;
  localparam int DW = 1, BW = 2, RW = 3, CW = 2, BUSY = 4;
  localparam int AW = DW + RW + BW + CW;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, iss_valid;
  logic [1:0] iss_cmd;
  logic [DW-1:0] iss_dev;
  logic [BW-1:0] iss_bank;
  logic [RW-1:0] iss_row;
  logic [CW-1:0] iss_col;

  dram_bank_pipe #(.DEV_W(DW), .BANK_W(BW), .ROW_W(RW), .COL_W(CW), .BUSY_CYC(BUSY)) u_dram_bank_pipe (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .iss_valid(iss_valid), .iss_cmd(iss_cmd), .iss_dev(iss_dev), .iss_bank(iss_bank),
    .iss_row(iss_row), .iss_col(iss_col));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, n_log = 0, acc_cyc = 0;
  bit stall_seen = 0;
  int l_cmd[32], l_dev[32], l_bank[32], l_row[32], l_col[32], l_cyc[32];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (iss_valid && n_log < 32) begin
      l_cmd[n_log] = iss_cmd; l_dev[n_log] = iss_dev; l_bank[n_log] = iss_bank;
      l_row[n_log] = iss_row; l_col[n_log] = iss_col; l_cyc[n_log] = cyc;
      n_log = n_log + 1;
    end
  end

  function automatic logic [AW-1:0] mk(int d, int r, int b, int c);
    return {DW'(d), RW'(r), BW'(b), CW'(c)};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; req_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1; n_log = 0; stall_seen = 0;
  endtask

  task automatic send(logic [AW-1:0] a);
    req_valid = 1; req_addr = a; #1;
    while (!req_ready) begin stall_seen = 1; @(negedge clk); #1; end
    @(negedge clk); #1;
    acc_cyc = cyc;
    req_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    repeat (2) @(negedge clk);
    #1;
    chk("R2 idle issue", int'(iss_valid), 0);
    chk("R2 ready", int'(req_ready), 1);
    chk("R2 no log", n_log, 0);
  endtask

  task automatic t_fields();
    int a;
    do_reset();
    send(mk(1, 5, 2, 3)); a = acc_cyc;
    repeat (4) @(negedge clk); #1;
    chk("R1 count", n_log, 1);
    chk("R1 dev", l_dev[0], 1);
    chk("R1 row", l_row[0], 5);
    chk("R1 bank", l_bank[0], 2);
    chk("R1 col", l_col[0], 3);
    chk("R3 empty cmd", l_cmd[0], 1);
    chk("R7 latency", l_cyc[0], a + 1);
  endtask

  task automatic t_hit_miss();
    do_reset();
    send(mk(0, 3, 1, 0)); repeat (10) @(negedge clk);
    send(mk(0, 3, 1, 2)); repeat (10) @(negedge clk);
    send(mk(0, 6, 1, 1)); repeat (10) @(negedge clk); #1;
    chk("R4 count", n_log, 3);
    chk("R3 first empty", l_cmd[0], 1);
    chk("R4 hit", l_cmd[1], 0);
    chk("R5 miss", l_cmd[2], 2);
  endtask

  task automatic t_forward();
    do_reset();
    send(mk(0, 1, 0, 0)); send(mk(0, 1, 0, 1));
    repeat (10) @(negedge clk); #1;
    chk("R6 hit count", n_log, 2);
    chk("R6 fwd hit", l_cmd[1], 0);
    chk("R9 hit not held", l_cyc[1], l_cyc[0] + 1);
    do_reset();
    send(mk(0, 1, 0, 0)); send(mk(0, 2, 0, 0));
    repeat (12) @(negedge clk); #1;
    chk("R6 miss count", n_log, 2);
    chk("R6 fwd miss", l_cmd[1], 2);
    chk("R8 release cycle", l_cyc[1], l_cyc[0] + BUSY + 1);
  endtask

  task automatic t_other_bank();
    do_reset();
    send(mk(0, 1, 0, 0)); send(mk(0, 4, 3, 0)); send(mk(0, 2, 0, 0));
    repeat (12) @(negedge clk); #1;
    chk("R10 count", n_log, 3);
    chk("R10 other bank bank", l_bank[1], 3);
    chk("R10 other bank cycle", l_cyc[1], l_cyc[0] + 1);
    chk("R10 other bank cmd", l_cmd[1], 1);
    chk("R8 held after other", l_cyc[2], l_cyc[0] + BUSY + 1);
  endtask

  task automatic t_order();
    bit st;
    do_reset();
    send(mk(0, 1, 0, 0)); send(mk(0, 2, 0, 0));
    send(mk(0, 0, 1, 0)); st = stall_seen;
    send(mk(0, 0, 2, 0)); st = st | stall_seen;
    repeat (12) @(negedge clk); #1;
    chk("R11 count", n_log, 4);
    chk("R11 stall seen", int'(st), 1);
    chk("R11 order bank1", l_bank[2], 1);
    chk("R11 order bank2", l_bank[3], 2);
    chk("R11 follow cycle", l_cyc[2], l_cyc[1] + 1);
    chk("R11 next cycle", l_cyc[3], l_cyc[2] + 1);
  endtask

  task automatic t_device();
    do_reset();
    send(mk(0, 1, 1, 0)); send(mk(1, 2, 1, 0));
    repeat (10) @(negedge clk); #1;
    chk("R12 count", n_log, 2);
    chk("R12 other dev cmd", l_cmd[1], 1);
    chk("R12 other dev cycle", l_cyc[1], l_cyc[0] + 1);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fields();
    t_hit_miss();
    t_forward();
    t_other_bank();
    t_order();
    t_device();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule